// File: doc/BRIEF.md
# Sample-Rate Converter Timing Strobe Generator

This block makes the sample timing pulses that drive up to ten sample-rate converters. Every converter has two sides, an input side and an output side, and each side needs a pulse once per sample. The block derives these pulses from one of two kinds of source. The first is a programmable divider that counts ticks of one of five audio clock sources. The second is the word-select strobe of one of ten serial audio ports.

Software writes 16-bit selector codes into two banks of paired registers, plus one register that enables the divider sources. The rate bank normally holds divider codes and the port bank holds word-select codes. A direction bit for each converter decides which bank drives the input pulse and which drives the output pulse.

Audio clock sources arrive as single-cycle tick enables in the block clock domain. Every pulse appears exactly one clock after the tick that causes it.

Top module: `rate_strobe_gen`

## Requirements
- R1: A selector code takes its source field from bits 15:8 and its divider index from bits 7:0. Source values 0 to 4 choose one of the five clock-source ticks (bit s of `src_tick`), and that side then divides those ticks.
- R2: Divider indexes 0, 1 and 2 give division ratios of 2, 4 and 6.
- R3: For index n from 3 to 28, an odd n gives a ratio of 2^((n+3)/2) and an even n gives 3·2^(n/2). Examples: index 3 gives 8, index 4 gives 12, index 9 gives 64, index 28 gives 49152.
- R4: Index 29 gives a ratio of 98304. Any index above 29 on a divider source produces no pulses.
- R5: A dividing side pulses for one cycle on every ratio-th enabled tick, counted from the last restart. Source value 6+n selects serial port n, and that side repeats `ws_tick` of the port one cycle later.
- R6: When `ws_share[n]` is set for the selected port n, the strobe is taken from another port. Ports 1 and 2 take port 0, port 4 takes port 3, and port 8 takes port 7. All other ports use their own strobe.
- R7: The write address selects a register. Addresses 0 to 4 hold the rate bank for converter pairs 0 to 4, and addresses 5 to 9 hold the port bank for the same pairs. In each register the even converter's code is in bits 15:0 and the odd converter's code is in bits 31:16.
- R8: When `dir_play[c]` is 1, `tim_in[c]` follows the rate-bank side and `tim_out[c]` follows the port-bank side. When it is 0, the two are swapped.
- R9: Address 10 is the source enable register, where bit s+1 enables source s. A disabled source holds its dividers at zero and they make no pulses, and bit 0 has no effect.
- R10: A write to a code register restarts the counters of both converters it holds. Neither side emits a pulse in the write cycle.
- R11: Source value 5, and any value at or above 6 plus the port count, produces no pulses.
- R12: Reset clears all codes, the enable register and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick | input | 5 | One-cycle ticks of the five audio clock sources |
| ws_tick | input | 10 | One-cycle word-select strobes of the serial ports |
| ws_share | input | 10 | Pin-sharing flag for each serial port |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| dir_play | input | 10 | Transfer direction per converter, 1 for playback |
| tim_in | output | 10 | Input-side timing pulse per converter |
| tim_out | output | 10 | Output-side timing pulse per converter |

## Verification
First, a steady tick on every source runs the ratios 2 through 64 side by side, so a wrong table entry or an off-by-one count shows up as a wrong pulse spacing. Next, random source ticks with random pin sharing separate tick counting from cycle counting and test the port routing map. Random changes of direction test the swap, repeated writes test the restart, and partial enable masks test the source gating. Finally, a long run with indexes 28 and 29 on one source checks the top of the table, including that the ratio after 49152 is 98304 and not 65536.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

    localparam int CODE_W = 16;
    localparam int CNT_W  = 17;
    localparam logic [7:0] MAX_IDX = 8'd29;
    localparam logic [7:0] WS_BASE = 8'h06;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_DIV,
        KIND_WS
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic [7:0]       line;
        logic [CNT_W-1:0] ratio;
    } sel_t;

    // division ratio for a divider index (valid for 0..29)
    function automatic logic [CNT_W-1:0] ratio_of(input logic [7:0] idx);
        logic [CNT_W-1:0] r;
        if (idx < 8'd3)
            r = CNT_W'({idx[1:0], 1'b0}) + CNT_W'(2);
        else if (idx == MAX_IDX)
            r = CNT_W'(98304);
        else if (idx[0])
            r = CNT_W'(1) << ((idx + 8'd3) >> 1);
        else
            r = CNT_W'(3) << (idx >> 1);
        return r;
    endfunction

    // port whose strobe a shared port borrows
    function automatic logic [7:0] ws_home(input logic [7:0] n, input logic shared);
        logic [7:0] h;
        h = n;
        if (shared) begin
            case (n)
                8'd1, 8'd2: h = 8'd0;
                8'd4:       h = 8'd3;
                8'd8:       h = 8'd7;
                default:    h = n;
            endcase
        end
        return h;
    endfunction

endpackage

// File: rtl/rsg_regs.sv
module rsg_regs
    import rsg_pkg::*;
#(
    parameter int NUM_CONV = 10,
    parameter int NUM_SRC  = 5,
    parameter int ADDR_W   = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [31:0]                      wr_data,
    output logic [NUM_CONV-1:0][CODE_W-1:0]  code_a,
    output logic [NUM_CONV-1:0][CODE_W-1:0]  code_b,
    output logic [NUM_CONV-1:0]              restart_a,
    output logic [NUM_CONV-1:0]              restart_b,
    output logic [NUM_SRC-1:0]               div_en
);

    localparam int NPAIR    = (NUM_CONV + 1) / 2;
    localparam int ENA_ADDR = 2 * NPAIR;

    always_comb begin
        for (int c = 0; c < NUM_CONV; c++) begin
            restart_a[c] = wr_en && (wr_addr == ADDR_W'(c / 2));
            restart_b[c] = wr_en && (wr_addr == ADDR_W'(NPAIR + c / 2));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_a <= '0;
            code_b <= '0;
            div_en <= '0;
        end else begin
            for (int c = 0; c < NUM_CONV; c++) begin
                if (restart_a[c])
                    code_a[c] <= (c % 2 == 1) ? wr_data[31:16] : wr_data[15:0];
                if (restart_b[c])
                    code_b[c] <= (c % 2 == 1) ? wr_data[31:16] : wr_data[15:0];
            end
            if (wr_en && wr_addr == ADDR_W'(ENA_ADDR))
                div_en <= wr_data[NUM_SRC:1];
        end
    end

endmodule

// File: rtl/rsg_chan.sv
module rsg_chan
    import rsg_pkg::*;
#(
    parameter int NUM_SRC = 5,
    parameter int NUM_WS  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    input  logic              restart,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [NUM_SRC-1:0] div_en,
    input  logic [NUM_WS-1:0] ws_tick,
    input  logic [NUM_WS-1:0] ws_share,
    output logic              strobe
);

    sel_t             dec;
    logic [7:0]       sel_f;
    logic [7:0]       idx_f;
    logic [7:0]       home;
    logic             shared;
    logic             tick_bit;
    logic             en_bit;
    logic             ws_bit;
    logic [CNT_W-1:0] cnt;

    // decode the selector code
    always_comb begin
        sel_f     = code[15:8];
        idx_f     = code[7:0];
        dec.kind  = KIND_NONE;
        dec.line  = '0;
        dec.ratio = ratio_of(idx_f);
        if (int'(sel_f) < NUM_SRC && idx_f <= MAX_IDX) begin
            dec.kind = KIND_DIV;
            dec.line = sel_f;
        end else if (sel_f >= WS_BASE && int'(sel_f) < int'(WS_BASE) + NUM_WS) begin
            dec.kind = KIND_WS;
            dec.line = sel_f - WS_BASE;
        end
    end

    // pick the tick, enable and strobe lines
    always_comb begin
        shared   = 1'b0;
        tick_bit = 1'b0;
        en_bit   = 1'b0;
        ws_bit   = 1'b0;
        for (int p = 0; p < NUM_WS; p++)
            if (dec.line == 8'(p)) shared = ws_share[p];
        home = ws_home(dec.line, shared);
        for (int p = 0; p < NUM_WS; p++)
            if (home == 8'(p)) ws_bit = ws_tick[p];
        for (int s = 0; s < NUM_SRC; s++)
            if (dec.line == 8'(s)) begin
                tick_bit = src_tick[s];
                en_bit   = div_en[s];
            end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= 1'b0;
            if (restart) begin
                cnt <= '0;
            end else begin
                case (dec.kind)
                    KIND_DIV: begin
                        if (!en_bit) begin
                            cnt <= '0;
                        end else if (tick_bit) begin
                            if (cnt >= dec.ratio - CNT_W'(1)) begin
                                cnt    <= '0;
                                strobe <= 1'b1;
                            end else begin
                                cnt <= cnt + CNT_W'(1);
                            end
                        end
                    end
                    KIND_WS: begin
                        cnt    <= '0;
                        strobe <= ws_bit;
                    end
                    default: cnt <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/rate_strobe_gen.sv
module rate_strobe_gen
    import rsg_pkg::*;
#(
    parameter int NUM_CONV = 10,
    parameter int NUM_SRC  = 5,
    parameter int NUM_WS   = 10,
    parameter int ADDR_W   = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  src_tick,
    input  logic [NUM_WS-1:0]   ws_tick,
    input  logic [NUM_WS-1:0]   ws_share,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [31:0]         wr_data,
    input  logic [NUM_CONV-1:0] dir_play,
    output logic [NUM_CONV-1:0] tim_in,
    output logic [NUM_CONV-1:0] tim_out
);

    logic [NUM_CONV-1:0][CODE_W-1:0] code_a;
    logic [NUM_CONV-1:0][CODE_W-1:0] code_b;
    logic [NUM_CONV-1:0]             restart_a;
    logic [NUM_CONV-1:0]             restart_b;
    logic [NUM_SRC-1:0]              div_en;
    logic [NUM_CONV-1:0]             str_a;
    logic [NUM_CONV-1:0]             str_b;

    rsg_regs #(
        .NUM_CONV (NUM_CONV),
        .NUM_SRC  (NUM_SRC),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .code_a    (code_a),
        .code_b    (code_b),
        .restart_a (restart_a),
        .restart_b (restart_b),
        .div_en    (div_en)
    );

    for (genvar c = 0; c < NUM_CONV; c++) begin : g_conv
        rsg_chan #(.NUM_SRC(NUM_SRC), .NUM_WS(NUM_WS)) u_rate (
            .clk      (clk),
            .rst      (rst),
            .code     (code_a[c]),
            .restart  (restart_a[c]),
            .src_tick (src_tick),
            .div_en   (div_en),
            .ws_tick  (ws_tick),
            .ws_share (ws_share),
            .strobe   (str_a[c])
        );
        rsg_chan #(.NUM_SRC(NUM_SRC), .NUM_WS(NUM_WS)) u_port (
            .clk      (clk),
            .rst      (rst),
            .code     (code_b[c]),
            .restart  (restart_b[c]),
            .src_tick (src_tick),
            .div_en   (div_en),
            .ws_tick  (ws_tick),
            .ws_share (ws_share),
            .strobe   (str_b[c])
        );
        assign tim_in[c]  = dir_play[c] ? str_a[c] : str_b[c];
        assign tim_out[c] = dir_play[c] ? str_b[c] : str_a[c];
    end

endmodule

// File: rtl/rsg_checker.sv
module rsg_checker #(
    parameter int NUM_CONV = 10,
    parameter int NUM_SRC  = 5,
    parameter int NUM_WS   = 10,
    parameter int ADDR_W   = 4
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_SRC-1:0]  src_tick,
    input logic [NUM_WS-1:0]   ws_tick,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [NUM_SRC-1:0]  div_en,
    input logic [NUM_CONV-1:0] str_a,
    input logic [NUM_CONV-1:0] tim_in,
    input logic [NUM_CONV-1:0] tim_out
);

    p_reset_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tim_in == '0 && tim_out == '0));

    p_no_stimulus_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(|src_tick) && !$past(|ws_tick)) |-> (tim_in == '0 && tim_out == '0));

    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(div_en) == '0 && !$past(|ws_tick)) |-> (tim_in == '0 && tim_out == '0));

    p_restart_silent_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && $past(wr_addr) == '0) |-> (str_a[1:0] == 2'b00));

endmodule

bind rate_strobe_gen rsg_checker #(
    .NUM_CONV (NUM_CONV),
    .NUM_SRC  (NUM_SRC),
    .NUM_WS   (NUM_WS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .src_tick (src_tick),
    .ws_tick  (ws_tick),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .div_en   (div_en),
    .str_a    (str_a),
    .tim_in   (tim_in),
    .tim_out  (tim_out)
);

// File: tb/rate_strobe_gen_test.sv
`timescale 1ns/1ps
module rate_strobe_gen_test;

    localparam int NC = 10;
    localparam int NS = 5;
    localparam int NW = 10;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] src_tick = '0;
    logic [NW-1:0] ws_tick  = '0;
    logic [NW-1:0] ws_share = '0;
    logic          wr_en    = 1'b0;
    logic [AW-1:0] wr_addr  = '0;
    logic [31:0]   wr_data  = '0;
    logic [NC-1:0] dir_play = '1;
    logic [NC-1:0] tim_in;
    logic [NC-1:0] tim_out;

    always #2.5 clk = ~clk;

    rate_strobe_gen uut (
        .clk(clk), .rst(rst), .src_tick(src_tick), .ws_tick(ws_tick),
        .ws_share(ws_share), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dir_play(dir_play), .tim_in(tim_in), .tim_out(tim_out)
    );

    typedef struct {
        logic [NC-1:0] ei;
        logic [NC-1:0] eo;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    // bench-side model state
    logic [15:0] m_a [NC];
    logic [15:0] m_b [NC];
    int          c_a [NC];
    int          c_b [NC];
    logic [NS-1:0] m_en = '0;

    function automatic int tb_ratio(input int idx);
        int r;
        if (idx <= 2) return 2 * (idx + 1);
        if (idx == 29) return 98304;
        r = 8;
        for (int k = 4; k <= idx; k++)
            r = (k % 2 == 0) ? (r * 3) / 2 : (r * 4) / 3;
        return r;
    endfunction

    function automatic int tb_home(input int p);
        if (!ws_share[p]) return p;
        if (p == 1 || p == 2) return 0;
        if (p == 4) return 3;
        if (p == 8) return 7;
        return p;
    endfunction

    function automatic bit side_next(input logic [15:0] code, input bit hit, inout int cnt);
        int sel;
        int idx;
        int h;
        sel = int'(code[15:8]);
        idx = int'(code[7:0]);
        if (hit) begin
            cnt = 0;
            return 1'b0;
        end
        if (sel < NS && idx <= 29) begin
            if (!m_en[sel]) begin
                cnt = 0;
                return 1'b0;
            end
            if (src_tick[sel]) begin
                if (cnt + 1 == tb_ratio(idx)) begin
                    cnt = 0;
                    return 1'b1;
                end
                cnt++;
            end
            return 1'b0;
        end
        cnt = 0;
        if (sel >= 6 && sel < 6 + NW) begin
            h = tb_home(sel - 6);
            return (h < NW) ? ws_tick[h] : 1'b0;
        end
        return 1'b0;
    endfunction

    // driver: one cycle of stimulus, expected result pushed to the scoreboard
    task automatic cyc(input string tag);
        exp_t e;
        bit   ha, hb, sa, sb;
        for (int c = 0; c < NC; c++) begin
            ha = wr_en && (int'(wr_addr) == c / 2);
            hb = wr_en && (int'(wr_addr) == 5 + c / 2);
            sa = side_next(m_a[c], ha, c_a[c]);
            sb = side_next(m_b[c], hb, c_b[c]);
            e.ei[c] = dir_play[c] ? sa : sb;
            e.eo[c] = dir_play[c] ? sb : sa;
        end
        e.tag = tag;
        q.push_back(e);
        if (wr_en) begin
            for (int c = 0; c < NC; c++) begin
                if (int'(wr_addr) == c / 2)     m_a[c] = (c % 2 == 1) ? wr_data[31:16] : wr_data[15:0];
                if (int'(wr_addr) == 5 + c / 2) m_b[c] = (c % 2 == 1) ? wr_data[31:16] : wr_data[15:0];
            end
            if (int'(wr_addr) == 10) m_en = wr_data[NS:1];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr(input int addr, input logic [31:0] data, input string tag);
        wr_en   = 1'b1;
        wr_addr = AW'(addr);
        wr_data = data;
        cyc(tag);
    endtask

    // monitor: compare design outputs with the queued expectation
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                n_checks++;
                if (tim_in !== e.ei || tim_out !== e.eo) begin
                    n_fail++;
                    $display("FAIL %s: tim_in=%h exp %h, tim_out=%h exp %h",
                             e.tag, tim_in, e.ei, tim_out, e.eo);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual hung expected finished");
        finish_run();
    end

    initial begin
        for (int c = 0; c < NC; c++) begin
            m_a[c] = '0; m_b[c] = '0; c_a[c] = 0; c_b[c] = 0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R12: reset state at the ports
        n_checks++;
        if (tim_in !== '0 || tim_out !== '0) begin
            n_fail++;
            $display("FAIL R12: tim_in=%h tim_out=%h expected 0", tim_in, tim_out);
        end
        // R12 / R9: codes cleared and all sources disabled after reset
        for (int i = 0; i < 20; i++) begin
            src_tick = '1;
            ws_tick  = '0;
            cyc("R12 R9 after reset");
        end

        // R7: program both banks
        wr(0, {16'h0101, 16'h0000}, "R7 write");
        wr(1, {16'h0303, 16'h0202}, "R7 write");
        wr(2, {16'h0405, 16'h0404}, "R7 write");
        wr(3, {16'h001E, 16'h0500}, "R7 write");
        wr(4, {16'h0009, 16'h1000}, "R7 write");
        for (int k = 0; k < 5; k++)
            wr(5 + k, {8'(7 + 2 * k), 8'h00, 8'(6 + 2 * k), 8'h00}, "R7 write");
        wr(10, 32'h0000_003E, "R9 enable");

        // steady ticks: ratio spacing on every divider
        for (int i = 0; i < 1500; i++) begin
            src_tick = '1;
            ws_tick  = NW'($urandom);
            cyc("R1 R2 R3 R4 R5 R7 R11 steady");
        end

        // random ticks and random pin sharing
        for (int i = 0; i < 1500; i++) begin
            src_tick = NS'($urandom);
            ws_tick  = NW'($urandom);
            if (i % 40 == 0) ws_share = NW'($urandom);
            cyc("R1 R5 R6 random");
        end

        // direction swapping
        for (int i = 0; i < 1000; i++) begin
            if (i % 50 == 0) dir_play = NC'($urandom);
            src_tick = NS'($urandom);
            ws_tick  = NW'($urandom);
            cyc("R8 direction");
        end
        dir_play = '1;
        ws_share = '0;

        // restart by rewriting code registers
        for (int i = 0; i < 300; i++) begin
            src_tick = '1;
            ws_tick  = NW'($urandom);
            if (i % 7 == 3)      wr(0, {16'h0101, 16'h0000}, "R10 restart");
            else if (i % 7 == 5) wr(2, {16'h0405, 16'h0404}, "R10 restart");
            else if (i % 11 == 6) wr(5, {16'h0700, 16'h0600}, "R10 restart");
            else                 cyc("R10 restart");
        end

        // enable gating
        wr(10, 32'h0000_0001, "R9 bit0 only");
        for (int i = 0; i < 200; i++) begin
            src_tick = '1;
            ws_tick  = '0;
            cyc("R9 bit0 only");
        end
        wr(10, 32'h0000_0004, "R9 source B only");
        for (int i = 0; i < 300; i++) begin
            src_tick = NS'($urandom);
            ws_tick  = NW'($urandom);
            cyc("R9 source B only");
        end

        // top of the ratio table
        wr(10, 32'h0000_003E, "R4 enable");
        wr(0, {16'h001D, 16'h001C}, "R3 R4 long");
        for (int i = 0; i < 98400; i++) begin
            src_tick = '1;
            ws_tick  = '0;
            cyc("R3 R4 long ratios");
        end
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule